// File: doc/BRIEF.md
# Dual-Mode Converter Data Front End

This block is the digital ingress stage that sits ahead of a pair of 12-bit current-steering converters. It takes sample words either from two separate buses, each with its own write strobe and update strobe, or from a single bus that carries I and Q words interleaved. A static mode input chooses between the two. It hands each converter a registered straight-binary code together with a one-cycle valid pulse whenever that code is refreshed.

All strobe pins are sampled on the block clock `clk`. A strobe's rising edge is taken at the first clock edge where the pin is sampled high after it was sampled low. The same four strobe pins have two meanings. In dual-port mode they are write A, update A, update B and write B. In interleaved mode they are the shared-bus write, the word-rate update clock, a hold input for that clock, and the I/Q steering select. In interleaved mode the update clock is divided by two inside the block. Both output codes then refresh together at half the word rate, and the pairing is fixed by clearing the divider while the hold input is high.

Top module: `dual_dac_ingress`

## Requirements
- R1: While `rst` is high at a clock edge, both output codes load mid-scale 2048 (binary 1000_0000_0000) and both valid outputs are low after that edge.
- R2: With `mode_dual` high, a rising edge on `strb_wa` captures `bus_a` into the channel A holding register, and a rising edge on `strb_wb` captures `bus_b` into the channel B holding register. A capture on its own does not change any output code.
- R3: With `mode_dual` high, a rising edge on `strb_ca` copies the channel A holding register to `code_a`, and a rising edge on `strb_cb` copies the channel B holding register to `code_b`. Each output is updated at the same clock edge at which its own rise is taken, and independently of the other channel.
- R4: When the write rise and the update rise of a channel are taken at the same clock edge, the output receives the value held before that edge. The new word reaches the output only on the following update.
- R5: With `mode_dual` low, a rising edge on `strb_wa` captures `bus_a` into holding register A when `strb_wb` (select) is high and into holding register B when it is low. `bus_b` has no effect on either code.
- R6: With `mode_dual` low, rising edges on `strb_ca` toggle a divide-by-two stage that starts at zero. Both outputs update together on every second such rise, counted from the release of `strb_cb` or from block reset.
- R7: With `mode_dual` low and `strb_cb` high, rises on `strb_ca` produce no update, both codes hold, and the divider is held at zero.
- R8: Codes are passed as straight binary with bit 11 as the MSB: 0 (zero scale) and 4095 (full scale) reach the output unchanged.
- R9: `code_a_vld` and `code_b_vld` are each high for exactly one clock cycle per update of their channel. A code never changes in a cycle where its channel does not update.
- R10: In interleaved mode, the select input may change only while both the shared write strobe and the update clock are low. The bench flags any change made at another time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_dual | input | 1 | 1 = two independent ports, 0 = interleaved I/Q port |
| bus_a | input | 12 | Channel A data bus, or the shared bus in interleaved mode |
| bus_b | input | 12 | Channel B data bus, unused in interleaved mode |
| strb_wa | input | 1 | Write strobe A / shared-bus write |
| strb_ca | input | 1 | Update strobe A / word-rate update clock |
| strb_cb | input | 1 | Update strobe B / update clock hold |
| strb_wb | input | 1 | Write strobe B / I-Q select (1 = A, 0 = B) |
| code_a | output | 12 | Registered code for converter A |
| code_a_vld | output | 1 | One-cycle pulse when `code_a` is refreshed |
| code_b | output | 12 | Registered code for converter B |
| code_b_vld | output | 1 | One-cycle pulse when `code_b` is refreshed |

## Verification
The bench builds the block with `DATA_W = 12`. At that width, mid-scale 2048 can be told apart from the zero and full-scale codes 0 and 4095, and the same-edge write/update case and the bus B bleed-through case each give a distinct value at the output. The four-pin reuse is exercised in both modes within one run. The interleaved pairing is checked across two separate releases of the clock hold, to show that the first update always falls on the second clock rise.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  typedef enum logic {
    MODE_IQ   = 1'b0,
    MODE_DUAL = 1'b1
  } fe_mode_e;

  // strobe pin slots; the order only matters inside this block
  localparam int PIN_WA = 0;
  localparam int PIN_CA = 1;
  localparam int PIN_CB = 2;
  localparam int PIN_WB = 3;
  localparam int NPINS  = 4;

endpackage

// File: rtl/dacfe_edge.sv
module dacfe_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // reset to 1 so a pin held high through reset is not taken as an edge
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b1;
      else     prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];

    AST_RISE_NOT_TWICE: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);  // R9
  end

endmodule

// File: rtl/dacfe_capture.sv
module dacfe_capture #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_dual,
  input  logic              rise_wa,
  input  logic              rise_wb,
  input  logic              sel_a,
  input  logic [DATA_W-1:0] bus_a,
  input  logic [DATA_W-1:0] bus_b,
  output logic [DATA_W-1:0] hold_a,
  output logic [DATA_W-1:0] hold_b
);

  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic ld_a, ld_b;
  logic [DATA_W-1:0] src_b;

  always_comb begin
    if (is_dual) begin
      ld_a  = rise_wa;
      ld_b  = rise_wb;
      src_b = bus_b;
    end else begin
      ld_a  = rise_wa & sel_a;
      ld_b  = rise_wa & ~sel_a;
      src_b = bus_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a <= MID;
      hold_b <= MID;
    end else begin
      if (ld_a) hold_a <= bus_a;
      if (ld_b) hold_b <= src_b;
    end
  end

  AST_IQ_B_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!is_dual && !(rise_wa && !sel_a)) |=> $stable(hold_b));  // R5
  AST_IQ_A_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!is_dual && !(rise_wa && sel_a)) |=> $stable(hold_a));  // R5
  AST_DUAL_A_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (is_dual && !rise_wa) |=> $stable(hold_a));  // R2

endmodule

// File: rtl/dacfe_update.sv
module dacfe_update #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_dual,
  input  logic              rise_ca,
  input  logic              rise_cb,
  input  logic              iq_hold,
  input  logic [DATA_W-1:0] hold_a,
  input  logic [DATA_W-1:0] hold_b,
  output logic [DATA_W-1:0] code_a,
  output logic              code_a_vld,
  output logic [DATA_W-1:0] code_b,
  output logic              code_b_vld
);

  localparam int NCH = 2;
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic              div_q;
  logic              iq_fire;
  logic [NCH-1:0]    upd;
  logic [DATA_W-1:0] src  [NCH];
  logic [DATA_W-1:0] code [NCH];
  logic [NCH-1:0]    vld;

  // divide-by-two of the word-rate clock; update on the rise that takes it 1 -> 0
  always_ff @(posedge clk) begin
    if (rst || is_dual || iq_hold) div_q <= 1'b0;
    else if (rise_ca)              div_q <= ~div_q;
  end

  assign iq_fire = rise_ca & ~iq_hold & div_q;
  assign upd[0]  = is_dual ? rise_ca : iq_fire;
  assign upd[1]  = is_dual ? rise_cb : iq_fire;
  assign src[0]  = hold_a;
  assign src[1]  = hold_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        code[c] <= MID;
        vld[c]  <= 1'b0;
      end else begin
        vld[c] <= upd[c];
        if (upd[c]) code[c] <= src[c];
      end
    end

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
      !upd[c] |=> $stable(code[c]));  // R9
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
      vld[c] |=> !vld[c]);  // R9
    AST_RESET_MID: assert property (@(posedge clk)
      rst |=> (code[c] == MID && !vld[c]));  // R1
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (!is_dual && iq_hold) |=> !vld[c]);  // R7
  end

  assign code_a     = code[0];
  assign code_b     = code[1];
  assign code_a_vld = vld[0];
  assign code_b_vld = vld[1];

  AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (!is_dual && iq_hold) |=> !div_q);  // R7
  AST_IQ_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
    !$past(is_dual) |-> (code_a_vld == code_b_vld));  // R6
  AST_IQ_SKIP_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!is_dual && rise_ca && !iq_hold && !div_q) |=> (!code_a_vld && div_q));  // R6

endmodule

// File: rtl/dual_dac_ingress.sv
module dual_dac_ingress
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_dual,
  input  logic [DATA_W-1:0] bus_a,
  input  logic [DATA_W-1:0] bus_b,
  input  logic              strb_wa,
  input  logic              strb_ca,
  input  logic              strb_cb,
  input  logic              strb_wb,
  output logic [DATA_W-1:0] code_a,
  output logic              code_a_vld,
  output logic [DATA_W-1:0] code_b,
  output logic              code_b_vld
);

  fe_mode_e          mode_e;
  logic              is_dual;
  logic [NPINS-1:0]  pins;
  logic [NPINS-1:0]  rise;
  logic [DATA_W-1:0] hold_a, hold_b;

  assign mode_e  = fe_mode_e'(mode_dual);
  assign is_dual = (mode_e == MODE_DUAL);

  always_comb begin
    pins         = '0;
    pins[PIN_WA] = strb_wa;
    pins[PIN_CA] = strb_ca;
    pins[PIN_CB] = strb_cb;
    pins[PIN_WB] = strb_wb;
  end

  dacfe_edge #(.N(NPINS)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pins),
    .rise (rise)
  );

  dacfe_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .is_dual (is_dual),
    .rise_wa (rise[PIN_WA]),
    .rise_wb (rise[PIN_WB]),
    .sel_a   (pins[PIN_WB]),
    .bus_a   (bus_a),
    .bus_b   (bus_b),
    .hold_a  (hold_a),
    .hold_b  (hold_b)
  );

  dacfe_update #(.DATA_W(DATA_W)) u_update (
    .clk        (clk),
    .rst        (rst),
    .is_dual    (is_dual),
    .rise_ca    (rise[PIN_CA]),
    .rise_cb    (rise[PIN_CB]),
    .iq_hold    (pins[PIN_CB]),
    .hold_a     (hold_a),
    .hold_b     (hold_b),
    .code_a     (code_a),
    .code_a_vld (code_a_vld),
    .code_b     (code_b),
    .code_b_vld (code_b_vld)
  );

endmodule

// File: tb/test_dual_dac_ingress.sv
module test_dual_dac_ingress;

  localparam int CLK_NS = 10;
  localparam int W      = 12;
  localparam int MID    = 2048;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_dual = 1'b1;
  logic [W-1:0] bus_a = '0, bus_b = '0;
  logic         strb_wa = 1'b0, strb_ca = 1'b0, strb_cb = 1'b0, strb_wb = 1'b0;
  logic [W-1:0] code_a, code_b;
  logic         code_a_vld, code_b_vld;

  int n_checks = 0;
  int n_fails  = 0;
  int sel_violations = 0;

  always #(CLK_NS/2) clk = ~clk;

  dual_dac_ingress #(.DATA_W(W)) i_dual_dac_ingress (
    .clk(clk), .rst(rst), .mode_dual(mode_dual),
    .bus_a(bus_a), .bus_b(bus_b),
    .strb_wa(strb_wa), .strb_ca(strb_ca), .strb_cb(strb_cb), .strb_wb(strb_wb),
    .code_a(code_a), .code_a_vld(code_a_vld),
    .code_b(code_b), .code_b_vld(code_b_vld)
  );

  // R10: select may only move while shared write and update clock are low
  always @(strb_wb) begin
    if (!mode_dual && !rst && (strb_wa || strb_ca)) sel_violations++;
  end

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic dual_write(input bit ch_b, input int d);
    if (ch_b) begin bus_b = W'(d); strb_wb = 1'b1; end
    else      begin bus_a = W'(d); strb_wa = 1'b1; end
    tick();
    strb_wa = 1'b0; strb_wb = 1'b0;
    tick();
  endtask

  // pulses one update strobe; returns what was seen right after the edge
  task automatic dual_update(input bit ch_b, output logic va, output logic vb,
                             output int ca, output int cb);
    if (ch_b) strb_cb = 1'b1; else strb_ca = 1'b1;
    tick();
    va = code_a_vld; vb = code_b_vld; ca = code_a; cb = code_b;
    strb_ca = 1'b0; strb_cb = 1'b0;
    tick();
  endtask

  task automatic iq_write(input bit sel, input int d, input int junk_b);
    strb_wb = sel;  // strobes are low here
    tick();
    bus_a = W'(d); bus_b = W'(junk_b); strb_wa = 1'b1;
    tick();
    strb_wa = 1'b0;
    tick();
  endtask

  task automatic iq_clock(output logic va, output logic vb, output int ca, output int cb);
    strb_ca = 1'b1;
    tick();
    va = code_a_vld; vb = code_b_vld; ca = code_a; cb = code_b;
    strb_ca = 1'b0;
    tick();
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) tick();
    check("R1 code_a after reset", code_a, MID);
    check("R1 code_b after reset", code_b, MID);
    check("R1 valids after reset", {code_a_vld, code_b_vld}, 0);
    rst = 1'b0;
    tick();
  endtask

  task automatic test_dual_ports();
    logic va, vb; int ca, cb;
    mode_dual = 1'b1;
    tick();
    dual_write(1'b0, 0);
    dual_write(1'b1, 4095);
    check("R2 capture leaves code_a", code_a, MID);
    check("R2 capture leaves code_b", code_b, MID);
    dual_update(1'b0, va, vb, ca, cb);
    check("R3 update A valid", va, 1);
    check("R3 update A leaves B idle", vb, 0);
    check("R8 zero code on A", ca, 0);
    check("R3 B unchanged by A update", cb, MID);
    check("R9 valid A is one cycle", code_a_vld, 0);
    dual_update(1'b1, va, vb, ca, cb);
    check("R3 update B valid", vb, 1);
    check("R3 update B leaves A idle", va, 0);
    check("R8 full-scale code on B", cb, 4095);
    check("R3 A unchanged by B update", ca, 0);
    dual_write(1'b0, 12'h5A3);
    dual_write(1'b1, 12'h0F1);
    dual_update(1'b1, va, vb, ca, cb);
    check("R3 B gets second word", cb, 12'h0F1);
    check("R3 A still old word", ca, 0);
    dual_update(1'b0, va, vb, ca, cb);
    check("R2 A gets second word", ca, 12'h5A3);
  endtask

  task automatic test_same_edge();
    logic va, vb; int ca, cb;
    bus_a = W'(12'hABC); strb_wa = 1'b1; strb_ca = 1'b1;
    tick();
    check("R4 same-edge valid", code_a_vld, 1);
    check("R4 same-edge takes old word", code_a, 12'h5A3);
    strb_wa = 1'b0; strb_ca = 1'b0;
    tick();
    dual_update(1'b0, va, vb, ca, cb);
    check("R4 new word on next update", ca, 12'hABC);
  endtask

  task automatic test_interleaved();
    logic va, vb; int ca, cb;
    strb_cb = 1'b1;  // hold the update clock before switching mode
    mode_dual = 1'b0;
    tick();
    strb_cb = 1'b0;
    tick();
    iq_write(1'b1, 12'h123, 12'hFFF);
    iq_write(1'b0, 12'h456, 12'hFFF);
    iq_clock(va, vb, ca, cb);
    check("R6 first clock rise does not update A", va, 0);
    check("R6 first clock rise does not update B", vb, 0);
    iq_clock(va, vb, ca, cb);
    check("R6 second rise updates A", va, 1);
    check("R6 second rise updates B", vb, 1);
    check("R5 select high steers to A", ca, 12'h123);
    check("R5 select low steers to B, bus B ignored", cb, 12'h456);
    iq_write(1'b0, 4095, 12'h000);
    iq_write(1'b1, 0, 12'h777);
    iq_clock(va, vb, ca, cb);
    check("R6 odd rise no update", va, 0);
    iq_clock(va, vb, ca, cb);
    check("R8 zero code via A", ca, 0);
    check("R8 full-scale code via B", cb, 4095);
    iq_clock(va, vb, ca, cb);  // divider now at one
    strb_cb = 1'b1;
    tick();
    iq_write(1'b1, 12'h321, 12'h999);
    iq_clock(va, vb, ca, cb);
    check("R7 hold blocks update", {va, vb}, 0);
    iq_clock(va, vb, ca, cb);
    check("R7 hold blocks update again", {va, vb}, 0);
    check("R7 A holds under hold", ca, 0);
    strb_cb = 1'b0;
    tick();
    iq_clock(va, vb, ca, cb);
    check("R6 first rise after release idle", {va, vb}, 0);
    iq_clock(va, vb, ca, cb);
    check("R6 second rise after release updates", {va, vb}, 3);
    check("R6 pairing A", ca, 12'h321);
    check("R6 pairing B", cb, 4095);
    check("R10 select changed only while strobes low", sel_violations, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    tick();
    test_reset();
    test_dual_ports();
    test_same_edge();
    test_interleaved();
    repeat (3) tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule